// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block gathers every interrupt condition of a 16550-style UART that also has automatic flow control, character matching and a sleep mode. Each condition is held in a pending flag until its own clear event arrives. Some flags clear on a read of the interrupt status register. Others clear on a read of the line-status, modem-status or receive holding register, or on a write to the transmit holding register. The rest clear on a later received character or on a matching Xon. The receive-data condition is not latched: it follows the receive FIFO level against its trigger.

The block also holds the receive character timeout counter. The counter runs while the receive FIFO holds data. It restarts on every received character and on every read of the receive holding register. It expires after four character times plus twelve bit times, where the character length in bits comes in as an input and the bit time is a parameter in clocks. The FIFOs, serializers and baud generator sit outside the block. Their state arrives as levels and single-cycle strobes.

From the pending flags and the per-source enables, a fixed priority chain forms a 6-bit identification code and one interrupt output. Reading the status register returns only the top enabled source. Lower sources stay queued until that source is serviced.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset no flag is pending, `isr_code` is 6'h01 and `irq` is 0.
- R2: Any nonzero bit of `line_err` (overrun, parity, framing, break) sets the line flag at the next edge. An `lsr_rd` clears it.
- R3: The receive-data condition is true while `rx_trig` is nonzero and `rx_level >= rx_trig`. It has no latch and ends as soon as the level drops below the trigger.
- R4: The timeout counter restarts on `rx_char_in` or `rx_hold_rd`, and it is held at zero while `rx_level` is 0. It sets the timeout flag on the edge where it has counted TICKS_PER_BIT*(4*frame_bits+12) clocks with data present. An `rx_hold_rd` clears the flag.
- R5: A low-to-high change of `tx_fifo_empty` or of `tx_at_trig` sets the transmit flag. Both previous levels count as high out of reset. A `thr_wr` clears the flag. An `isr_rd` clears it only while 6'h02 is the reported code.
- R6: Any nonzero bit of `modem_delta` sets the modem flag. An `msr_rd` clears it.
- R7: `xoff_seen` sets the Xoff flag. An `xon_seen` clears it. An `isr_rd` also clears it while 6'h10 is reported.
- R8: `spec_seen` sets the special-character flag. The next `rx_char_in` without `spec_seen` clears it. An `isr_rd` also clears it while 6'h10 is reported.
- R9: While `auto_cts_on` is set, a low-to-high change of `cts_pin` sets the CTS flag. While `auto_rts_on` is set, a low-to-high change of `rts_pin` does the same for the RTS flag. Both previous levels count as high out of reset. An `msr_rd` clears both flags. The CTS flag is enabled only when `src_en[6]` and `enh_mode` are both 1.
- R10: `sleep_exit` sets the wake flag. An `isr_rd` clears it only while 6'h30 is reported.
- R11: `isr_code` reports the first enabled pending source, from highest to lowest: line 6'h06, timeout 6'h0C, receive data 6'h04, transmit 6'h02, modem 6'h00, Xoff or special 6'h10, CTS or RTS 6'h20, wake 6'h30. With none pending it reports 6'h01.
- R12: `irq` is 1 exactly when some pending flag is enabled. The enable bits in `src_en` are: [0] receive data and timeout, [1] transmit, [2] line, [3] modem, [4] Xoff and special, [5] RTS, [6] CTS, [7] wake. A disabled flag stays latched and is reported once it is enabled.
- R13: When a set event and a clear event reach the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_bits | input | 4 | Bits per character frame, used for the timeout |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_trig | input | LVL_W | Receive trigger level (0 disables the receive-data condition) |
| rx_char_in | input | 1 | Strobe: a character entered the receive FIFO |
| rx_hold_rd | input | 1 | Strobe: receive holding register read |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_at_trig | input | 1 | Transmit FIFO at or below its trigger level |
| thr_wr | input | 1 | Strobe: transmit holding register write |
| line_err | input | 4 | Line error strobes: overrun, parity, framing, break |
| lsr_rd | input | 1 | Strobe: line-status register read |
| modem_delta | input | 4 | Modem change strobes: CTS, DSR, RI trailing edge, CD |
| msr_rd | input | 1 | Strobe: modem-status register read |
| xoff_seen | input | 1 | Strobe: Xoff character matched |
| xon_seen | input | 1 | Strobe: Xon character(s) matched |
| spec_seen | input | 1 | Strobe: special character matched |
| auto_cts_on | input | 1 | Automatic CTS flow control active |
| auto_rts_on | input | 1 | Automatic RTS flow control active |
| cts_pin | input | 1 | CTS input level |
| rts_pin | input | 1 | RTS output level driven by the receiver |
| sleep_exit | input | 1 | Strobe: the UART left sleep mode |
| isr_rd | input | 1 | Strobe: interrupt status register read |
| src_en | input | 8 | Per-source enables (layout in R12) |
| enh_mode | input | 1 | Enhanced-feature bit that unlocks the CTS enable |
| irq | output | 1 | Interrupt request |
| isr_code | output | 6 | Identification code of the top enabled source |

## Verification
A wrong flag shows at the ports through `isr_code` and `irq` in the cycle after the faulty edge, provided the flag is enabled and no higher-priority source hides it. The bench therefore runs random stimulus with frequent enable changes and compares both outputs every cycle against a model built from the requirements. A counter that is off by one shows the timeout code one cycle early or late. A clear applied to the wrong source leaves a code visible where 6'h01 or a lower code is expected. Directed cases cover same-cycle set and clear, clears on an isr read when the flag is not the reported source, and edges from pins that were high out of reset.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int NSRC   = 10;
  localparam int S_LINE = 0;
  localparam int S_TOUT = 1;
  localparam int S_RXD  = 2;
  localparam int S_TXR  = 3;
  localparam int S_MDM  = 4;
  localparam int S_XOFF = 5;
  localparam int S_SPEC = 6;
  localparam int S_CTS  = 7;
  localparam int S_RTS  = 8;
  localparam int S_WAKE = 9;

  typedef enum logic [5:0] {
    ID_MDM  = 6'h00,
    ID_NONE = 6'h01,
    ID_TXR  = 6'h02,
    ID_RXD  = 6'h04,
    ID_LINE = 6'h06,
    ID_TOUT = 6'h0C,
    ID_FLOW = 6'h10,
    ID_HSK  = 6'h20,
    ID_WAKE = 6'h30
  } irq_id_e;

  // Fixed priority chain over enabled pending flags.
  function automatic irq_id_e pick_id(input logic [NSRC-1:0] act);
    if (act[S_LINE])                    return ID_LINE;
    else if (act[S_TOUT])               return ID_TOUT;
    else if (act[S_RXD])                return ID_RXD;
    else if (act[S_TXR])                return ID_TXR;
    else if (act[S_MDM])                return ID_MDM;
    else if (act[S_XOFF] | act[S_SPEC]) return ID_FLOW;
    else if (act[S_CTS] | act[S_RTS])   return ID_HSK;
    else if (act[S_WAKE])               return ID_WAKE;
    else                                return ID_NONE;
  endfunction

  // Four characters plus twelve bits, in clocks.
  function automatic int unsigned tout_limit(input logic [3:0] fbits,
                                             input int unsigned tpb);
    return (4 * int'(fbits) + 12) * tpb;
  endfunction
endpackage

// File: rtl/uart_irq_flag.sv
`timescale 1ns/1ps
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

  // R13: set beats a simultaneous clear
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  a_r13_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/uart_irq_tout.sv
`timescale 1ns/1ps
module uart_irq_tout
  import uart_irq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int LVL_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       frame_bits,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             restart,
  output logic             fire
);
  localparam int MAXLIM = 72 * TICKS_PER_BIT;
  localparam int CW     = $clog2(MAXLIM + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          has_data;
  logic          running;

  assign lim      = CW'(tout_limit(frame_bits, TICKS_PER_BIT));
  assign has_data = (rx_level != '0);
  assign running  = has_data && !restart && (cnt < lim);
  assign fire     = running && ((cnt + 1'b1) == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart || !has_data) cnt <= '0;
    else if (cnt < lim)            cnt <= cnt + 1'b1;
  end

  // R4: empty FIFO holds the counter at zero
  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !has_data |=> (cnt == '0));
  // R4: expiry is a single pulse per restart
  a_r4_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/uart_irq_arb.sv
`timescale 1ns/1ps
module uart_irq_arb
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act,
  output irq_id_e         id,
  output logic            irq,
  output logic [NSRC-1:0] served
);
  always_comb begin
    id             = pick_id(act);
    irq            = |act;
    served         = '0;
    served[S_TXR]  = (id == ID_TXR);
    served[S_XOFF] = (id == ID_FLOW);
    served[S_SPEC] = (id == ID_FLOW);
    served[S_WAKE] = (id == ID_WAKE);
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH    = 32,
  parameter int TICKS_PER_BIT = 16,
  localparam int LVL_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       frame_bits,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_char_in,
  input  logic             rx_hold_rd,
  input  logic             tx_fifo_empty,
  input  logic             tx_at_trig,
  input  logic             thr_wr,
  input  logic [3:0]       line_err,
  input  logic             lsr_rd,
  input  logic [3:0]       modem_delta,
  input  logic             msr_rd,
  input  logic             xoff_seen,
  input  logic             xon_seen,
  input  logic             spec_seen,
  input  logic             auto_cts_on,
  input  logic             auto_rts_on,
  input  logic             cts_pin,
  input  logic             rts_pin,
  input  logic             sleep_exit,
  input  logic             isr_rd,
  input  logic [7:0]       src_en,
  input  logic             enh_mode,
  output logic             irq,
  output logic [5:0]       isr_code
);
  // Named internal events
  logic prev_txe, prev_txt, prev_cts, prev_rts;
  logic tx_rise, cts_rise, rts_rise;
  logic rx_at_trig;
  logic tout_fire;
  logic [NSRC-1:0] set_v, clr_v, pend, en_v, act, served;
  irq_id_e id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_txe <= 1'b1;
      prev_txt <= 1'b1;
      prev_cts <= 1'b1;
      prev_rts <= 1'b1;
    end else begin
      prev_txe <= tx_fifo_empty;
      prev_txt <= tx_at_trig;
      prev_cts <= cts_pin;
      prev_rts <= rts_pin;
    end
  end

  assign tx_rise    = (tx_fifo_empty & ~prev_txe) | (tx_at_trig & ~prev_txt);
  assign cts_rise   = auto_cts_on & cts_pin & ~prev_cts;
  assign rts_rise   = auto_rts_on & rts_pin & ~prev_rts;
  assign rx_at_trig = (rx_trig != '0) && (rx_level >= rx_trig);

  uart_irq_tout #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .LVL_W        (LVL_W)
  ) u_tout (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_bits(frame_bits),
    .rx_level  (rx_level),
    .restart   (rx_char_in | rx_hold_rd),
    .fire      (tout_fire)
  );

  always_comb begin
    set_v         = '0;
    clr_v         = '0;
    set_v[S_LINE] = |line_err;
    clr_v[S_LINE] = lsr_rd;
    set_v[S_TOUT] = tout_fire;
    clr_v[S_TOUT] = rx_hold_rd;
    set_v[S_RXD]  = rx_at_trig;
    set_v[S_TXR]  = tx_rise;
    clr_v[S_TXR]  = thr_wr | (isr_rd & served[S_TXR]);
    set_v[S_MDM]  = |modem_delta;
    clr_v[S_MDM]  = msr_rd;
    set_v[S_XOFF] = xoff_seen;
    clr_v[S_XOFF] = xon_seen | (isr_rd & served[S_XOFF]);
    set_v[S_SPEC] = spec_seen;
    clr_v[S_SPEC] = rx_char_in | (isr_rd & served[S_SPEC]);
    set_v[S_CTS]  = cts_rise;
    clr_v[S_CTS]  = msr_rd;
    set_v[S_RTS]  = rts_rise;
    clr_v[S_RTS]  = msr_rd;
    set_v[S_WAKE] = sleep_exit;
    clr_v[S_WAKE] = isr_rd & served[S_WAKE];
  end

  always_comb begin
    en_v         = '0;
    en_v[S_LINE] = src_en[2];
    en_v[S_TOUT] = src_en[0];
    en_v[S_RXD]  = src_en[0];
    en_v[S_TXR]  = src_en[1];
    en_v[S_MDM]  = src_en[3];
    en_v[S_XOFF] = src_en[4];
    en_v[S_SPEC] = src_en[4];
    en_v[S_RTS]  = src_en[5];
    en_v[S_CTS]  = src_en[6] & enh_mode;
    en_v[S_WAKE] = src_en[7];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == S_RXD) begin : g_level
      assign pend[i] = set_v[i] & ~clr_v[i];
    end else begin : g_latch
      uart_irq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_v[i]),
        .clr  (clr_v[i]),
        .q    (pend[i])
      );
    end
  end

  assign act = pend & en_v;

  uart_irq_arb u_arb (
    .act   (act),
    .id    (id),
    .irq   (irq),
    .served(served)
  );

  assign isr_code = id;

  // R2: a line-status read with no new error empties the line flag
  a_r2_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && line_err == 4'd0) |=> !pend[S_LINE]);
  // R4: receive holding read removes a timeout
  a_r4_tout_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hold_rd |=> !pend[S_TOUT]);
  // R5: a holding write without a new edge drops the transmit flag
  a_r5_thr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !tx_rise) |=> !pend[S_TXR]);
  // R6: modem read clears modem flag
  a_r6_msr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && modem_delta == 4'd0) |=> !pend[S_MDM]);
  // R8: a plain next character ends the special-character flag
  a_r8_next_char: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_in && !spec_seen) |=> !pend[S_SPEC]);
  // R9: a rising pin outside automatic flow control sets nothing
  a_r9_cts_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_cts_on && !pend[S_CTS]) |=> !pend[S_CTS]);
  // R11: line status always wins when enabled
  a_r11_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    act[S_LINE] |-> (isr_code == 6'h06));
  // R11: at most one source group is served by a status read
  a_r11_one_served: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({served[S_TXR], served[S_XOFF], served[S_WAKE]}));
  // R12: request agrees with the reported code
  a_r12_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (isr_code != 6'h01));
endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
  localparam int FD  = 32;
  localparam int TPB = 2;
  localparam int LW  = $clog2(FD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] frame_bits;
  logic [LW-1:0] rx_level, rx_trig;
  logic rx_char_in, rx_hold_rd, tx_fifo_empty, tx_at_trig, thr_wr;
  logic [3:0] line_err, modem_delta;
  logic lsr_rd, msr_rd, xoff_seen, xon_seen, spec_seen;
  logic auto_cts_on, auto_rts_on, cts_pin, rts_pin, sleep_exit, isr_rd;
  logic [7:0] src_en;
  logic enh_mode;
  logic irq;
  logic [5:0] isr_code;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(FD), .TICKS_PER_BIT(TPB)) u0 (.*);

  int nchk = 0, nbad = 0;
  bit done = 0;

  // model state
  bit m_ls, m_to, m_tx, m_ms, m_xo, m_sp, m_ct, m_rt, m_wk;
  bit p_txe, p_txt, p_cts, p_rts;
  int m_cnt;

  function automatic logic [5:0] exp_id();
    bit rxd;
    rxd = (rx_trig != 0) && (rx_level >= rx_trig);
    if (src_en[2] && m_ls) return 6'h06;
    if (src_en[0] && m_to) return 6'h0C;
    if (src_en[0] && rxd) return 6'h04;
    if (src_en[1] && m_tx) return 6'h02;
    if (src_en[3] && m_ms) return 6'h00;
    if (src_en[4] && (m_xo || m_sp)) return 6'h10;
    if ((src_en[6] && enh_mode && m_ct) || (src_en[5] && m_rt)) return 6'h20;
    if (src_en[7] && m_wk) return 6'h30;
    return 6'h01;
  endfunction

  function automatic int lim_of(input logic [3:0] fb);
    return TPB * (12 + 4 * int'(fb));
  endfunction

  task automatic model_step();
    logic [5:0] c;
    bit fire;
    c = exp_id();
    fire = 0;
    if (rx_char_in || rx_hold_rd || rx_level == 0) m_cnt = 0;
    else if (m_cnt < lim_of(frame_bits)) begin
      m_cnt++;
      if (m_cnt == lim_of(frame_bits)) fire = 1;
    end
    m_to = fire || (m_to && !rx_hold_rd);
    m_ls = (line_err != 0) || (m_ls && !lsr_rd);
    m_ms = (modem_delta != 0) || (m_ms && !msr_rd);
    m_tx = (tx_fifo_empty && !p_txe) || (tx_at_trig && !p_txt) ||
           (m_tx && !thr_wr && !(isr_rd && c == 6'h02));
    m_xo = xoff_seen || (m_xo && !xon_seen && !(isr_rd && c == 6'h10));
    m_sp = spec_seen || (m_sp && !rx_char_in && !(isr_rd && c == 6'h10));
    m_ct = (auto_cts_on && cts_pin && !p_cts) || (m_ct && !msr_rd);
    m_rt = (auto_rts_on && rts_pin && !p_rts) || (m_rt && !msr_rd);
    m_wk = sleep_exit || (m_wk && !(isr_rd && c == 6'h30));
    p_txe = tx_fifo_empty; p_txt = tx_at_trig; p_cts = cts_pin; p_rts = rts_pin;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk); #1;
    chk(tag, {2'b0, isr_code}, {2'b0, exp_id()});
    chk(tag, {7'b0, irq}, {7'b0, exp_id() != 6'h01});
  endtask

  task automatic idle();
    rx_char_in = 0; rx_hold_rd = 0; thr_wr = 0; line_err = 0; lsr_rd = 0;
    modem_delta = 0; msr_rd = 0; xoff_seen = 0; xon_seen = 0; spec_seen = 0;
    sleep_exit = 0; isr_rd = 0;
  endtask

  initial begin
    idle();
    frame_bits = 4'd10; rx_level = 0; rx_trig = 4; tx_fifo_empty = 0;
    tx_at_trig = 0; auto_cts_on = 0; auto_rts_on = 0; cts_pin = 0; rts_pin = 0;
    src_en = 8'hFF; enh_mode = 1;
    {m_ls, m_to, m_tx, m_ms, m_xo, m_sp, m_ct, m_rt, m_wk} = '0;
    {p_txe, p_txt, p_cts, p_rts} = 4'hF;
    m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset code", {2'b0, isr_code}, 8'h01);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    tick("R1");

    // R2 line status
    line_err = 4'b0001; tick("R2"); idle(); tick("R2");
    chk("R2 held", {2'b0, isr_code}, 8'h06);
    lsr_rd = 1; tick("R2"); idle();
    chk("R2 cleared", {2'b0, isr_code}, 8'h01);
    // R13 set and clear together
    line_err = 4'b0010; lsr_rd = 1; tick("R13"); idle();
    chk("R13 set wins", {2'b0, isr_code}, 8'h06);
    lsr_rd = 1; tick("R13"); idle();

    // R3 receive level
    rx_level = 3; tick("R3");
    chk("R3 below", {2'b0, isr_code}, 8'h01);
    rx_level = 4; tick("R3");
    chk("R3 at trig", {2'b0, isr_code}, 8'h04);
    rx_level = 3; rx_hold_rd = 1; tick("R3"); idle();
    chk("R3 drained", {2'b0, isr_code}, 8'h01);

    // R4 timeout
    rx_level = 2; rx_char_in = 1; tick("R4"); idle();
    for (int k = 0; k < lim_of(4'd10) - 1; k++) tick("R4");
    chk("R4 not yet", {2'b0, isr_code}, 8'h01);
    tick("R4");
    chk("R4 expired", {2'b0, isr_code}, 8'h0C);
    rx_hold_rd = 1; tick("R4"); idle();
    chk("R4 rhr clear", {2'b0, isr_code}, 8'h01);
    rx_level = 0;
    for (int k = 0; k < lim_of(4'd10) + 4; k++) tick("R4 empty");
    chk("R4 empty no timeout", {2'b0, isr_code}, 8'h01);

    // R5 transmit
    tx_fifo_empty = 1; tick("R5");
    chk("R5 empty rise", {2'b0, isr_code}, 8'h02);
    isr_rd = 1; tick("R5"); idle();
    chk("R5 isr clear", {2'b0, isr_code}, 8'h01);
    tx_at_trig = 1; tick("R5");
    chk("R5 trig rise", {2'b0, isr_code}, 8'h02);
    thr_wr = 1; tick("R5"); idle();
    chk("R5 thr clear", {2'b0, isr_code}, 8'h01);

    // R6 modem
    modem_delta = 4'b1000; tick("R6"); idle();
    chk("R6 set", {2'b0, isr_code}, 8'h00);
    msr_rd = 1; tick("R6"); idle();
    chk("R6 clear", {2'b0, isr_code}, 8'h01);

    // R7 Xoff
    xoff_seen = 1; tick("R7"); idle();
    chk("R7 set", {2'b0, isr_code}, 8'h10);
    xon_seen = 1; tick("R7"); idle();
    chk("R7 xon clear", {2'b0, isr_code}, 8'h01);

    // R8 special
    spec_seen = 1; rx_char_in = 1; tick("R8"); idle();
    chk("R8 set", {2'b0, isr_code}, 8'h10);
    rx_char_in = 1; tick("R8"); idle();
    chk("R8 next char clear", {2'b0, isr_code}, 8'h01);
    spec_seen = 1; tick("R8"); idle();
    isr_rd = 1; tick("R8"); idle();
    chk("R8 isr clear", {2'b0, isr_code}, 8'h01);

    // R9 / R12 CTS and RTS
    enh_mode = 0; auto_cts_on = 1; cts_pin = 1; tick("R9");
    chk("R9 cts locked", {2'b0, isr_code}, 8'h01);
    enh_mode = 1; tick("R12");
    chk("R12 latched shows", {2'b0, isr_code}, 8'h20);
    msr_rd = 1; tick("R9"); idle();
    chk("R9 msr clear", {2'b0, isr_code}, 8'h01);
    auto_rts_on = 1; rts_pin = 1; tick("R9");
    chk("R9 rts rise", {2'b0, isr_code}, 8'h20);
    msr_rd = 1; tick("R9"); idle();
    auto_cts_on = 0; cts_pin = 0; tick("R9"); cts_pin = 1; tick("R9");
    chk("R9 no auto", {2'b0, isr_code}, 8'h01);

    // R10 wake
    sleep_exit = 1; tick("R10"); idle();
    chk("R10 set", {2'b0, isr_code}, 8'h30);
    isr_rd = 1; tick("R10"); idle();
    chk("R10 clear", {2'b0, isr_code}, 8'h01);

    // R11 ordering
    line_err = 1; modem_delta = 1; sleep_exit = 1; tick("R11"); idle();
    chk("R11 line top", {2'b0, isr_code}, 8'h06);
    lsr_rd = 1; tick("R11"); idle();
    chk("R11 modem next", {2'b0, isr_code}, 8'h00);
    isr_rd = 1; tick("R11"); idle();
    chk("R11 wake kept", {2'b0, isr_code}, 8'h00);
    msr_rd = 1; tick("R11"); idle();
    chk("R11 wake last", {2'b0, isr_code}, 8'h30);
    isr_rd = 1; tick("R11"); idle();

    // R12 enable gating
    src_en = 8'h00; line_err = 4'b0100; tick("R12"); idle();
    chk("R12 masked irq", {7'b0, irq}, 8'h00);
    src_en = 8'hFF; tick("R12");
    chk("R12 unmasked", {2'b0, isr_code}, 8'h06);
    lsr_rd = 1; tick("R12"); idle();

    // constrained random
    void'($urandom(32'd1357));
    for (int blk = 0; blk < 40; blk++) begin
      frame_bits = 4'($urandom_range(7, 11));
      rx_trig = LW'($urandom_range(0, 16));
      for (int n = 0; n < 150; n++) begin
        idle();
        if ($urandom_range(0, 31) == 0) rx_level = LW'($urandom_range(0, FD));
        rx_char_in = ($urandom_range(0, 63) == 0);
        rx_hold_rd = ($urandom_range(0, 63) == 0);
        if ($urandom_range(0, 15) == 0) tx_fifo_empty = ~tx_fifo_empty;
        if ($urandom_range(0, 15) == 0) tx_at_trig = ~tx_at_trig;
        thr_wr = ($urandom_range(0, 15) == 0);
        if ($urandom_range(0, 15) == 0) line_err = 4'($urandom);
        lsr_rd = ($urandom_range(0, 7) == 0);
        if ($urandom_range(0, 15) == 0) modem_delta = 4'($urandom);
        msr_rd = ($urandom_range(0, 7) == 0);
        xoff_seen = ($urandom_range(0, 15) == 0);
        xon_seen = ($urandom_range(0, 15) == 0);
        spec_seen = ($urandom_range(0, 15) == 0);
        if ($urandom_range(0, 31) == 0) auto_cts_on = ~auto_cts_on;
        if ($urandom_range(0, 31) == 0) auto_rts_on = ~auto_rts_on;
        if ($urandom_range(0, 7) == 0) cts_pin = ~cts_pin;
        if ($urandom_range(0, 7) == 0) rts_pin = ~rts_pin;
        sleep_exit = ($urandom_range(0, 31) == 0);
        isr_rd = ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 15) == 0) src_en = 8'($urandom);
        if ($urandom_range(0, 31) == 0) enh_mode = ~enh_mode;
        tick("R11 random");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule